// File: doc/BRIEF.md
# Indirect Interrupt Controller Register Window

This block is the register front end of an I/O interrupt controller with a parameterised number of input pins (24 by default). Software reaches the controller through two 32-bit locations on a simple register bus. One holds an 8-bit select value. The other is a data window that reads or writes whichever internal register the select value names. The internal registers are an identifier register, a read-only version register, an arbitration register and a redirection table with one 64-bit entry per pin. Each entry is reached as two 32-bit halves.

The block owns the redirection table. It drives every entry's fields in parallel to the pin-service logic: vector, delivery mode, destination mode, polarity, trigger mode, mask, remote-IRR and destination. The pin-service logic sets and clears each remote-IRR bit and supplies each delivery-status bit; both bits are read-only from the bus. A bus write that changes an entry's mask bit produces a one-cycle event that carries the pin number and the new mask value.

The bus has no back-pressure. A write strobe or a read strobe is accepted in every cycle in which it is high, and there is no ready signal. Read data is registered and appears after the clock edge that samples the read strobe. The event output is a plain one-cycle pulse with no handshake, so the consumer must sample it in that cycle.

Top module: `intc_regwin`

## Requirements
- R1: Offset 0x00 is the select register and offset 0x10 is the data window. A read at any other byte offset returns zero, and a write at any other offset changes no state.
- R2: A write to the select register stores bits 7:0 of the write data. A read of the select register returns the stored value, with bits 31:8 zero.
- R3: Window index 0x00 is the identifier register. A write stores data bits 27:24, and a read returns the identifier in bits 27:24 with all other bits zero. Index 0x02 reads the same value, and writes to index 0x02 are ignored.
- R4: Window index 0x01 reads (NUM_PINS-1) in bits 23:16 and 0x11 in bits 7:0, which is 0x00170011 for 24 pins. Writes to index 0x01 are ignored.
- R5: Index 0x10+2n is the low word of entry n and index 0x11+2n is its high word. The low word holds:
  - vector in bits 7:0
  - delivery mode in bits 10:8
  - destination mode in bit 11
  - delivery status in bit 12
  - polarity in bit 13
  - remote-IRR in bit 14
  - trigger mode in bit 15
  - mask in bit 16

  The high word holds the destination in bits 31:24. All other bits read as zero. Each written field appears on the entry's field outputs after the write edge.
- R6: A write to the high word changes only the destination and leaves every low-word field unchanged, remote-IRR included.
- R7: A write to the low word clears that entry's remote-IRR bit. The bus cannot set remote-IRR; it is set by rirr_set_i and cleared by rirr_clr_i. The delivery-status bit reads the level of dstat_i.
- R8: Indices 0x03 to 0x0F, and redirection indices at or past 0x10+2*NUM_PINS, read as 0xFFFFFFFF. Writes to them are ignored.
- R9: A low-word write that changes an entry's mask bit raises mask_evt_o for the single cycle after the write edge, with the pin number and the new mask value. A low-word write that leaves the mask bit unchanged raises no event.
- R10: After reset every mask bit is 1. Every other entry field, the select register, the identifier and the read data are 0.
- R11: bus_rdata_o is loaded at each clock edge where bus_rd_i is high, from the state before any write in the same cycle. It holds its value when bus_rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 8 | Byte offset inside the 256-byte range |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| rirr_set_i | input | NUM_PINS | Per-pin remote-IRR set from the service logic |
| rirr_clr_i | input | NUM_PINS | Per-pin remote-IRR clear (end of interrupt) |
| dstat_i | input | NUM_PINS | Per-pin delivery-status level |
| ent_vector_o | output | NUM_PINS*8 | Vector of each entry |
| ent_dlv_o | output | NUM_PINS*3 | Delivery mode of each entry |
| ent_dest_mode_o | output | NUM_PINS | Destination mode of each entry |
| ent_polarity_o | output | NUM_PINS | Polarity of each entry |
| ent_trig_o | output | NUM_PINS | Trigger mode of each entry |
| ent_mask_o | output | NUM_PINS | Mask bit of each entry |
| ent_rirr_o | output | NUM_PINS | Remote-IRR bit of each entry |
| ent_dest_o | output | NUM_PINS*8 | Destination of each entry |
| mask_evt_o | output | 1 | One-cycle mask-change event |
| mask_evt_pin_o | output | $clog2(NUM_PINS) | Pin of the mask-change event |
| mask_evt_val_o | output | 1 | New mask value of the event |

## Verification
The bench builds the block with the default of 24 pins. With that value the last valid redirection index is 0x3F, so select values 0x40 to 0xFF test the out-of-range rule, and 0x03 to 0x0F test the gap below the table. It also makes the version word a specific 0x00170011. Random select values drawn over the full 8-bit range reach both gaps, the identifier aliasing at index 0x02 and mask toggling on every pin.

// File: rtl/intc_regwin_pkg.sv
package intc_regwin_pkg;
  localparam int unsigned SEL_W  = 8;
  localparam int unsigned WORD_W = 32;

  // low-word bit positions
  localparam int unsigned B_DM    = 11;
  localparam int unsigned B_DSTAT = 12;
  localparam int unsigned B_POL   = 13;
  localparam int unsigned B_RIRR  = 14;
  localparam int unsigned B_TRIG  = 15;
  localparam int unsigned B_MASK  = 16;

  localparam logic [SEL_W-1:0] IDX_ID    = 8'h00;
  localparam logic [SEL_W-1:0] IDX_VER   = 8'h01;
  localparam logic [SEL_W-1:0] IDX_ARB   = 8'h02;
  localparam logic [SEL_W-1:0] IDX_TABLE = 8'h10;

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;

  typedef enum logic [1:0] {ACC_NONE, ACC_SEL, ACC_WIN} acc_e;
  typedef enum logic [2:0] {TGT_ID, TGT_VER, TGT_ARB, TGT_ENT, TGT_BAD} tgt_e;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dm;
    logic [2:0] dlv;
    logic [7:0] vec;
  } ent_t;
endpackage

// File: rtl/intc_regwin_decode.sv
module intc_regwin_decode
  import intc_regwin_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned PIN_W = $clog2(NUM_PINS)
) (
  input  logic [7:0]       addr,
  input  logic [SEL_W-1:0] sel,
  output acc_e             acc,
  output tgt_e             tgt,
  output logic [PIN_W-1:0] pin,
  output logic             hi_half
);
  logic [SEL_W-1:0] off;
  logic [SEL_W-2:0] pin_full;

  always_comb begin
    if (addr == OFF_SEL)      acc = ACC_SEL;
    else if (addr == OFF_WIN) acc = ACC_WIN;
    else                      acc = ACC_NONE;
  end

  assign off      = sel - IDX_TABLE;
  assign pin_full = off[SEL_W-1:1];
  assign hi_half  = off[0];
  assign pin      = pin_full[PIN_W-1:0];

  always_comb begin
    if (sel == IDX_ID)                              tgt = TGT_ID;
    else if (sel == IDX_VER)                        tgt = TGT_VER;
    else if (sel == IDX_ARB)                        tgt = TGT_ARB;
    else if (sel < IDX_TABLE)                       tgt = TGT_BAD;
    else if (32'(pin_full) < NUM_PINS)              tgt = TGT_ENT;
    else                                            tgt = TGT_BAD;
  end

  always_comb begin
    if (tgt == TGT_ENT) a_r5_pin_in_range: assert (32'(pin) < NUM_PINS);
  end
endmodule

// File: rtl/intc_regwin_table.sv
module intc_regwin_table
  import intc_regwin_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned PIN_W = $clog2(NUM_PINS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [PIN_W-1:0]      wr_pin,
  input  logic [WORD_W-1:0]     wdata,
  input  logic [NUM_PINS-1:0]   rirr_set,
  input  logic [NUM_PINS-1:0]   rirr_clr,
  output ent_t [NUM_PINS-1:0]   ents,
  output logic [NUM_PINS-1:0]   rirr,
  output logic                  evt,
  output logic [PIN_W-1:0]      evt_pin,
  output logic                  evt_val
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[23:17], wdata[B_RIRR], wdata[B_DSTAT]};

  logic cur_mask;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_ent
      logic hit_lo, hit_hi;
      assign hit_lo = wr_lo && (wr_pin == PIN_W'(g));
      assign hit_hi = wr_hi && (wr_pin == PIN_W'(g));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ents[g]      <= '0;
          ents[g].mask <= 1'b1;
        end else begin
          if (hit_lo) begin
            ents[g].vec  <= wdata[7:0];
            ents[g].dlv  <= wdata[10:8];
            ents[g].dm   <= wdata[B_DM];
            ents[g].pol  <= wdata[B_POL];
            ents[g].trig <= wdata[B_TRIG];
            ents[g].mask <= wdata[B_MASK];
          end
          if (hit_hi) ents[g].dest <= wdata[31:24];
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n)                      rirr[g] <= 1'b0;
        else if (hit_lo || rirr_clr[g])  rirr[g] <= 1'b0;
        else if (rirr_set[g])            rirr[g] <= 1'b1;
      end

      a_r7_low_write_clears_rirr: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo |=> !rirr[g]);
      a_r6_high_write_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hi |=> ($stable(ents[g].vec) && $stable(ents[g].mask) &&
                    $stable(ents[g].trig) && $stable(ents[g].dlv)));
    end
  endgenerate

  always_comb begin
    cur_mask = 1'b0;
    for (int i = 0; i < NUM_PINS; i++)
      if (wr_pin == PIN_W'(i)) cur_mask = ents[i].mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt     <= 1'b0;
      evt_pin <= '0;
      evt_val <= 1'b0;
    end else begin
      evt     <= wr_lo && (cur_mask != wdata[B_MASK]);
      evt_pin <= wr_pin;
      evt_val <= wdata[B_MASK];
    end
  end

  a_r9_event_only_after_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(wr_lo));
endmodule

// File: rtl/intc_regwin_rdmux.sv
module intc_regwin_rdmux
  import intc_regwin_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter logic [7:0]  VERSION  = 8'h11,
  localparam int unsigned PIN_W = $clog2(NUM_PINS)
) (
  input  acc_e                acc,
  input  tgt_e                tgt,
  input  logic [PIN_W-1:0]    pin,
  input  logic                hi_half,
  input  logic [SEL_W-1:0]    sel,
  input  logic [3:0]          id,
  input  ent_t [NUM_PINS-1:0] ents,
  input  logic [NUM_PINS-1:0] rirr,
  input  logic [NUM_PINS-1:0] dstat,
  output logic [WORD_W-1:0]   word
);
  localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

  ent_t        e;
  logic        e_rirr, e_ds;
  logic [31:0] lo_word, hi_word, win_word;

  always_comb begin
    e      = '0;
    e_rirr = 1'b0;
    e_ds   = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (pin == PIN_W'(i)) begin
        e      = ents[i];
        e_rirr = rirr[i];
        e_ds   = dstat[i];
      end
    end
  end

  always_comb begin
    lo_word          = '0;
    lo_word[7:0]     = e.vec;
    lo_word[10:8]    = e.dlv;
    lo_word[B_DM]    = e.dm;
    lo_word[B_DSTAT] = e_ds;
    lo_word[B_POL]   = e.pol;
    lo_word[B_RIRR]  = e_rirr;
    lo_word[B_TRIG]  = e.trig;
    lo_word[B_MASK]  = e.mask;
    hi_word          = {e.dest, 24'h0};
  end

  always_comb begin
    case (tgt)
      TGT_ID, TGT_ARB: win_word = {4'h0, id, 24'h0};
      TGT_VER:         win_word = {8'h0, MAX_PIN, 8'h0, VERSION};
      TGT_ENT:         win_word = hi_half ? hi_word : lo_word;
      default:         win_word = '1;
    endcase
  end

  always_comb begin
    case (acc)
      ACC_SEL: word = {24'h0, sel};
      ACC_WIN: word = win_word;
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/intc_regwin.sv
module intc_regwin
  import intc_regwin_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter logic [7:0]  VERSION  = 8'h11,
  localparam int unsigned PIN_W = $clog2(NUM_PINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              bus_addr_i,
  input  logic [31:0]             bus_wdata_i,
  input  logic                    bus_wr_i,
  input  logic                    bus_rd_i,
  output logic [31:0]             bus_rdata_o,
  input  logic [NUM_PINS-1:0]     rirr_set_i,
  input  logic [NUM_PINS-1:0]     rirr_clr_i,
  input  logic [NUM_PINS-1:0]     dstat_i,
  output logic [NUM_PINS*8-1:0]   ent_vector_o,
  output logic [NUM_PINS*3-1:0]   ent_dlv_o,
  output logic [NUM_PINS-1:0]     ent_dest_mode_o,
  output logic [NUM_PINS-1:0]     ent_polarity_o,
  output logic [NUM_PINS-1:0]     ent_trig_o,
  output logic [NUM_PINS-1:0]     ent_mask_o,
  output logic [NUM_PINS-1:0]     ent_rirr_o,
  output logic [NUM_PINS*8-1:0]   ent_dest_o,
  output logic                    mask_evt_o,
  output logic [PIN_W-1:0]        mask_evt_pin_o,
  output logic                    mask_evt_val_o
);
  logic [SEL_W-1:0]    sel_q;
  logic [3:0]          id_q;
  acc_e                acc;
  tgt_e                tgt;
  logic [PIN_W-1:0]    pin;
  logic                hi_half;
  ent_t [NUM_PINS-1:0] ents;
  logic [NUM_PINS-1:0] rirr;
  logic [31:0]         rd_word;
  logic                wr_win, wr_lo, wr_hi;

  intc_regwin_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .addr(bus_addr_i), .sel(sel_q), .acc(acc), .tgt(tgt), .pin(pin), .hi_half(hi_half)
  );

  assign wr_win = bus_wr_i && (acc == ACC_WIN);
  assign wr_lo  = wr_win && (tgt == TGT_ENT) && !hi_half;
  assign wr_hi  = wr_win && (tgt == TGT_ENT) && hi_half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (bus_wr_i && (acc == ACC_SEL))   sel_q <= bus_wdata_i[7:0];
      if (wr_win && (tgt == TGT_ID))      id_q  <= bus_wdata_i[27:24];
    end
  end

  intc_regwin_table #(.NUM_PINS(NUM_PINS)) u_tab (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_pin(pin),
    .wdata(bus_wdata_i), .rirr_set(rirr_set_i), .rirr_clr(rirr_clr_i),
    .ents(ents), .rirr(rirr), .evt(mask_evt_o), .evt_pin(mask_evt_pin_o),
    .evt_val(mask_evt_val_o)
  );

  intc_regwin_rdmux #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_rd (
    .acc(acc), .tgt(tgt), .pin(pin), .hi_half(hi_half), .sel(sel_q), .id(id_q),
    .ents(ents), .rirr(rirr), .dstat(dstat_i), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_word;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_out
      assign ent_vector_o[g*8 +: 8] = ents[g].vec;
      assign ent_dlv_o[g*3 +: 3]    = ents[g].dlv;
      assign ent_dest_mode_o[g]     = ents[g].dm;
      assign ent_polarity_o[g]      = ents[g].pol;
      assign ent_trig_o[g]          = ents[g].trig;
      assign ent_mask_o[g]          = ents[g].mask;
      assign ent_rirr_o[g]          = rirr[g];
      assign ent_dest_o[g*8 +: 8]   = ents[g].dest;
    end
  endgenerate

  a_r9_event_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt_o |-> (ent_mask_o[mask_evt_pin_o] == mask_evt_val_o));
  a_r1_other_offset_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i != OFF_SEL && bus_addr_i != OFF_WIN) |=> (bus_rdata_o == '0));
  a_r8_bad_index_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == OFF_WIN && sel_q > IDX_ARB &&
     (sel_q < IDX_TABLE || 32'(sel_q) >= 32'(IDX_TABLE) + 2*NUM_PINS))
    |=> ($stable(ent_mask_o) && $stable(ent_vector_o) && $stable(ent_dest_o)));
  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));
  a_r10_masked_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&ent_mask_o));
endmodule

// File: tb/intc_regwin_tb_top.sv
module intc_regwin_tb_top;
  localparam int unsigned NUM_PINS = 24;
  localparam int unsigned PIN_W = $clog2(NUM_PINS);
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] LO_WR = 32'h0001_AFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [31:0] bus_rdata_o;
  logic [NUM_PINS-1:0] rirr_set_i = '0, rirr_clr_i = '0, dstat_i = '0;
  logic [NUM_PINS*8-1:0] ent_vector_o, ent_dest_o;
  logic [NUM_PINS*3-1:0] ent_dlv_o;
  logic [NUM_PINS-1:0] ent_dest_mode_o, ent_polarity_o, ent_trig_o, ent_mask_o, ent_rirr_o;
  logic mask_evt_o, mask_evt_val_o;
  logic [PIN_W-1:0] mask_evt_pin_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_regwin #(.NUM_PINS(NUM_PINS)) dut_i (.*);

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [31:0] m_lo [NUM_PINS];
  logic [7:0]  m_hi [NUM_PINS];
  logic [NUM_PINS-1:0] m_rirr;
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic        x_evt;
  logic [PIN_W-1:0] x_evt_pin;
  logic        x_evt_val;
  logic        g_evt, g_evt_val;
  logic [PIN_W-1:0] g_evt_pin;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a, input logic [7:0] s);
    if (a != 8'h00 && a != 8'h10) return "R1";
    if (a == 8'h00) return "R2";
    if (s == 8'h00 || s == 8'h02) return "R3";
    if (s == 8'h01) return "R4";
    if (s < 8'h10 || 32'(s) >= 32'h10 + 2*NUM_PINS) return "R8";
    return "R5";
  endfunction

  function automatic logic [31:0] win_read(input logic [7:0] s);
    int p;
    if (s == 8'h00 || s == 8'h02) return {4'h0, m_id, 24'h0};
    if (s == 8'h01) return {8'h0, 8'(NUM_PINS-1), 8'h0, 8'h11};
    if (s < 8'h10) return 32'hFFFF_FFFF;
    p = (int'(s) - 16) >> 1;
    if (p >= NUM_PINS) return 32'hFFFF_FFFF;
    if (s[0]) return {m_hi[p], 24'h0};
    return m_lo[p] | (32'(m_rirr[p]) << 14) | (32'(dstat_i[p]) << 12);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return {24'h0, m_sel};
    if (a == 8'h10) return win_read(m_sel);
    return 32'h0;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int p;
    x_evt = 1'b0; x_evt_pin = '0; x_evt_val = 1'b0;
    if (a == 8'h00) m_sel = d[7:0];
    else if (a == 8'h10) begin
      if (m_sel == 8'h00) m_id = d[27:24];
      else if (m_sel >= 8'h10) begin
        p = (int'(m_sel) - 16) >> 1;
        if (p < NUM_PINS) begin
          if (m_sel[0]) m_hi[p] = d[31:24];
          else begin
            x_evt = (m_lo[p][16] != d[16]);
            x_evt_pin = PIN_W'(p);
            x_evt_val = d[16];
            m_lo[p] = d & LO_WR;
            m_rirr[p] = 1'b0;
          end
        end
      end
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
    g_evt = mask_evt_o; g_evt_pin = mask_evt_pin_o; g_evt_val = mask_evt_val_o;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] r);
    @(negedge clk);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(negedge clk);
    bus_rd_i = 1'b0;
    r = bus_rdata_o;
  endtask

  task automatic read_check(input logic [7:0] a);
    logic [31:0] r;
    logic [31:0] e;
    e = exp_read(a);
    bus_read(a, r);
    check(tag_of(a, m_sel), r, e);
  endtask

  task automatic write_check(input logic [7:0] a, input logic [31:0] d);
    bus_write(a, d);
    check("R9 evt", 32'(g_evt), 32'(x_evt));
    if (x_evt) begin
      check("R9 pin", 32'(g_evt_pin), 32'(x_evt_pin));
      check("R9 val", 32'(g_evt_val), 32'(x_evt_val));
    end
  endtask

  function automatic logic [7:0] pick_sel();
    if ($urandom % 100 < 75) return 8'(16 + $urandom % (2*NUM_PINS));
    return 8'($urandom % 256);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NUM_PINS; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = '0; end
    m_rirr = '0; m_sel = '0; m_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 rdata", bus_rdata_o, 32'h0);
    check("R10 masks", 32'(ent_mask_o), 32'(NUM_PINS == 32 ? '1 : (32'd1 << NUM_PINS) - 1));
    check("R10 vectors", 32'(|ent_vector_o), 32'h0);
    read_check(8'h00);
    read_check(8'h10);
    bus_write(8'h00, 32'h0000_0010);
    read_check(8'h10);

    // R2 select keeps low 8 bits
    bus_write(8'h00, 32'hABCD_EF01);
    read_check(8'h00);
    // R4 version, write ignored
    write_check(8'h10, 32'hFFFF_FFFF);
    read_check(8'h10);
    // R3 id and arbitration alias
    bus_write(8'h00, 32'h0);
    write_check(8'h10, 32'hF5FF_FFFF);
    read_check(8'h10);
    bus_write(8'h00, 32'h2);
    write_check(8'h10, 32'h0A00_0000);
    read_check(8'h10);
    // R8 gap and past-end
    bus_write(8'h00, 32'h07);
    write_check(8'h10, 32'h0);
    read_check(8'h10);
    bus_write(8'h00, 32'h40);
    write_check(8'h10, 32'h0);
    read_check(8'h10);
    check("R8 masks kept", 32'(&ent_mask_o), 32'h1);
    // R1 other offset
    bus_write(8'h20, 32'h1234_5678);
    read_check(8'h20);
    read_check(8'h00);

    // R7 remote-IRR and delivery status on pin 3
    bus_write(8'h00, 32'h16);
    write_check(8'h10, 32'h0000_8031);
    @(negedge clk); rirr_set_i[3] = 1'b1; m_rirr[3] = 1'b1;
    @(negedge clk); rirr_set_i[3] = 1'b0;
    check("R7 rirr port", 32'(ent_rirr_o[3]), 32'h1);
    write_check(8'h10, 32'h0000_4000 | 32'h0000_8031 | 32'h0001_0000);
    check("R7 bus write cleared rirr", 32'(ent_rirr_o[3]), 32'h0);
    @(negedge clk); rirr_set_i[3] = 1'b1; m_rirr[3] = 1'b1;
    @(negedge clk); rirr_set_i[3] = 1'b0;
    bus_write(8'h00, 32'h17);
    write_check(8'h10, 32'h9C00_0000); // R6 high write
    check("R6 rirr kept", 32'(ent_rirr_o[3]), 32'h1);
    check("R6 dest port", 32'(ent_dest_o[3*8 +: 8]), 32'h9C);
    bus_write(8'h00, 32'h16);
    read_check(8'h10);
    @(negedge clk); rirr_clr_i[3] = 1'b1; m_rirr[3] = 1'b0;
    @(negedge clk); rirr_clr_i[3] = 1'b0;
    check("R7 clr input", 32'(ent_rirr_o[3]), 32'h0);
    dstat_i[3] = 1'b1;
    read_check(8'h10);
    dstat_i[3] = 1'b0;

    // R11 rdata holds without strobe
    @(negedge clk); bus_addr_i = 8'h00;
    @(negedge clk);
    check("R11 hold", bus_rdata_o, {m_lo[3] | (32'(m_rirr[3]) << 14) | 32'h1000});

    // random phase
    for (int it = 0; it < 600; it++) begin
      int k;
      k = $urandom % 10;
      if (k < 3)      bus_write(8'h00, {$urandom} & 32'hFFFF_FF00 | 32'(pick_sel()));
      else if (k < 6) write_check(8'h10, $urandom);
      else if (k < 8) read_check(8'h10);
      else if (k < 9) read_check(8'h00);
      else begin
        logic [7:0] a;
        a = 8'($urandom % 256);
        if ($urandom % 2) bus_write(a, $urandom);
        else read_check(a);
      end
    end

    // R5 field outputs against model
    for (int p = 0; p < NUM_PINS; p++) begin
      check("R5 vec", 32'(ent_vector_o[p*8 +: 8]), 32'(m_lo[p][7:0]));
      check("R5 dlv", 32'(ent_dlv_o[p*3 +: 3]), 32'(m_lo[p][10:8]));
      check("R5 fields", {28'h0, ent_dest_mode_o[p], ent_polarity_o[p], ent_trig_o[p], ent_mask_o[p]},
            {28'h0, m_lo[p][11], m_lo[p][13], m_lo[p][15], m_lo[p][16]});
      check("R5 dest", 32'(ent_dest_o[p*8 +: 8]), 32'(m_hi[p]));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule